// File: doc/BRIEF.md
# Infrared Receive Edge-Capture Timer

This block times the pulses arriving on an infrared receive line. The line is brought into the clock domain through a two-flop synchroniser. A two-bit select chooses which transitions count as qualifying edges: falling, rising or both. A fourth code turns capture off. On every qualifying edge the block stores the value of a free-running interval counter and the new level of the line, and raises a sticky capture flag. It can also restart the counter from zero, so that successive captures give pulse and gap widths directly.

The counter advances on every module clock when full resolution is selected. Otherwise it advances on a tick derived from a carrier divider value D, which gives one tick every 2*(D+1) clocks. The block only works while it is enabled and set to receive. Leaving that state clears the counter and the carrier prescaler.

Top module: `ir_edge_capture_timer`

## Requirements
- R1: The block is active only while `enable_i`=1 and `mode_tx_i`=0. While it is inactive, no edge produces a capture.
- R2: `edge_sel_i` encodes the edges that qualify: 2'b00 means falling only, 2'b01 rising only, 2'b10 both, and 2'b11 none, which disables capture.
- R3: On a capture, `rx_level_o` takes the synchronised line level after the edge. `cap_count_o` takes the counter value held before any update in that cycle.
- R4: With `reload_en_i`=1 the counter is 0 in the cycle after a capture. With `reload_en_i`=0 it keeps counting through captures.
- R5: With `clk_direct_i`=1 the counter increments by one on every clock while the block is active.
- R6: With `clk_direct_i`=0 the counter increments once every 2*(`carrier_div_i`+1) clocks, counted from activation. A divider value of 0 therefore gives one step every second clock.
- R7: A transition on `rx_pin_i` is captured at the third rising clock edge after the change. This is two synchroniser stages plus the capture register.
- R8: `cap_flag_o` is set by each capture and stays set until `cap_flag_clr_i` is high at a clock edge. A capture in the same cycle wins over the clear.
- R9: When the counter wraps from all ones to zero, `ovf_flag_o` is set and stays set until `ovf_flag_clr_i` is high at a clock edge.
- R10: Making the block inactive clears the counter and the carrier prescaler. After reactivation, counts start from zero.
- R11: During reset and just after it, `cap_count_o`, `rx_level_o`, `cap_flag_o` and `ovf_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Block enable |
| mode_tx_i | input | 1 | 1 = transmit mode (receive timing halted) |
| edge_sel_i | input | 2 | Qualifying edge select |
| clk_direct_i | input | 1 | 1 = count every clock, 0 = count carrier ticks |
| reload_en_i | input | 1 | Clear counter on each capture |
| carrier_div_i | input | DIV_W (16) | Carrier divider value D |
| rx_pin_i | input | 1 | Asynchronous infrared receive line |
| cap_flag_clr_i | input | 1 | Clear strobe for the capture flag |
| ovf_flag_clr_i | input | 1 | Clear strobe for the overflow flag |
| cap_count_o | output | CNT_W (16) | Counter value stored at the last capture |
| rx_level_o | output | 1 | Line level stored at the last capture |
| cap_flag_o | output | 1 | Sticky capture flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
A counter that is not cleared correctly shows up in the next captured count as an offset that grows with every missed reload or every inactive period. A wrong prescaler phase changes the tick-mode counts by one step within the first capture. A fault in the edge history or the select decode shows up as a missing capture or an extra capture three clocks after the line changes. The scoreboard reports both cases at once. A wrong wrap detection only becomes visible after a full 2^16-clock run, so the overflow flag is checked at the exact edge where the wrap happens and one edge before it.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [1:0] {
    SEL_FALL = 2'b00,
    SEL_RISE = 2'b01,
    SEL_BOTH = 2'b10,
    SEL_NONE = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ir_rst_sync.sv
module ir_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  assign stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/ir_edge_detect.sv
module ir_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic [1:0] edge_sel_i,
  input  logic       rx_async_i,
  output logic       rx_sync_o,
  output logic       capture_o
);
  import ir_cap_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hist_q, hist_d;
  logic                   rise, fall, match;

  // the history register tracks the line while idle, so no stale edge appears on activation
  assign sync_d    = {sync_q[SYNC_STAGES-2:0], rx_async_i};
  assign rx_sync_o = sync_q[SYNC_STAGES-1];
  assign hist_d    = rx_sync_o;
  assign rise      = rx_sync_o & ~hist_q;
  assign fall      = ~rx_sync_o & hist_q;

  always_comb begin
    unique case (edge_sel_e'(edge_sel_i))
      SEL_FALL: match = fall;
      SEL_RISE: match = rise;
      SEL_BOTH: match = rise | fall;
      default:  match = 1'b0;
    endcase
  end

  assign capture_o = active_i & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  // R2: reserved select never yields a capture
  a_r2_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == 2'b11) |-> !capture_o);
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_q, half_d;
  logic             phase_q, phase_d;
  logic             half_done;

  assign half_done = (half_q >= div_i);
  assign tick_o    = run_i & half_done & phase_q;

  always_comb begin
    half_d  = half_q;
    phase_d = phase_q;
    if (!run_i) begin
      half_d  = '0;
      phase_d = 1'b0;
    end else if (half_done) begin
      half_d  = '0;
      phase_d = ~phase_q;
    end else begin
      half_d  = half_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      half_q  <= half_d;
      phase_q <= phase_d;
    end
  end

  // R6: a carrier tick is never followed by another on the next clock
  a_r6_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ir_interval_counter.sv
module ir_interval_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             step_i,
  input  logic             capture_i,
  input  logic             reload_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (!active_i) begin
      cnt_d = '0;
    end else if (capture_i && reload_en_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = &cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4: reload on capture restarts the count
  a_r4_reload_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && capture_i && reload_en_i) |=> (cnt_q == '0));
  // R5: each step advances the count by one
  a_r5_step_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && step_i && !capture_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10: inactive state holds the counter at zero
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/ir_edge_capture_timer.sv
module ir_edge_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             mode_tx_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             clk_direct_i,
  input  logic             reload_en_i,
  input  logic [DIV_W-1:0] carrier_div_i,
  input  logic             rx_pin_i,
  input  logic             cap_flag_clr_i,
  input  logic             ovf_flag_clr_i,
  output logic [CNT_W-1:0] cap_count_o,
  output logic             rx_level_o,
  output logic             cap_flag_o,
  output logic             ovf_flag_o
);
  logic             rst_n;
  logic             active, rx_sync, capture, tick, step, wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_cnt_q, cap_cnt_d;
  logic             lvl_q, lvl_d, cflag_q, cflag_d, oflag_q, oflag_d;

  assign active = enable_i & ~mode_tx_i;

  ir_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  ir_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_n), .active_i(active), .edge_sel_i(edge_sel_i),
    .rx_async_i(rx_pin_i), .rx_sync_o(rx_sync), .capture_o(capture));

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(active & ~clk_direct_i),
    .div_i(carrier_div_i), .tick_o(tick));

  assign step = clk_direct_i ? 1'b1 : tick;

  ir_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .active_i(active), .step_i(step),
    .capture_i(capture), .reload_en_i(reload_en_i), .cnt_o(cnt), .wrap_o(wrap));

  always_comb begin
    cap_cnt_d = capture ? cnt : cap_cnt_q;
    lvl_d     = capture ? rx_sync : lvl_q;
    cflag_d   = capture | (cflag_q & ~cap_flag_clr_i);
    oflag_d   = wrap | (oflag_q & ~ovf_flag_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt_q <= '0;
      lvl_q     <= 1'b0;
      cflag_q   <= 1'b0;
      oflag_q   <= 1'b0;
    end else begin
      cap_cnt_q <= cap_cnt_d;
      lvl_q     <= lvl_d;
      cflag_q   <= cflag_d;
      oflag_q   <= oflag_d;
    end
  end

  assign cap_count_o = cap_cnt_q;
  assign rx_level_o  = lvl_q;
  assign cap_flag_o  = cflag_q;
  assign ovf_flag_o  = oflag_q;

  // R1: no new capture while inactive
  a_r1_idle_no_capture: assert property (@(posedge clk_i) disable iff (!rst_n)
    !active |=> !$rose(cap_flag_o));
  // R2: reserved select never raises the flag
  a_r2_reserved_no_flag: assert property (@(posedge clk_i) disable iff (!rst_n)
    (edge_sel_i == 2'b11) |=> !$rose(cap_flag_o));
  // R8: flag holds until cleared
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cap_flag_o && !cap_flag_clr_i) |=> cap_flag_o);
  // R9: overflow flag rises only together with a wrapped counter
  a_r9_ovf_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> (cnt == '0));
endmodule

// File: tb/ir_edge_capture_timer_bench.sv
module ir_edge_capture_timer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] cnt;
    logic        lvl;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, mode_tx = 1'b0, clk_direct = 1'b1, reload = 1'b1;
  logic [1:0]  edge_sel = 2'b00;
  logic [15:0] div = 16'd0;
  logic        rx_pin = 1'b1, cflag_clr = 1'b0, oflag_clr = 1'b0;
  logic [15:0] cap_count;
  logic        rx_level, cap_flag, ovf_flag;

  int    cyc = 0, total = 0, bad = 0, en_cyc = 0, base = 0;
  bit    finished = 1'b0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ir_edge_capture_timer u_ir_edge_capture_timer (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_tx_i(mode_tx),
    .edge_sel_i(edge_sel), .clk_direct_i(clk_direct), .reload_en_i(reload),
    .carrier_div_i(div), .rx_pin_i(rx_pin), .cap_flag_clr_i(cflag_clr),
    .ovf_flag_clr_i(oflag_clr), .cap_count_o(cap_count), .rx_level_o(rx_level),
    .cap_flag_o(cap_flag), .ovf_flag_o(ovf_flag));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // change activity; counter and prescaler restart from this point (R10)
  task automatic set_run(input logic en, input logic tx);
    @(negedge clk);
    enable = en; mode_tx = tx;
    en_cyc = cyc; base = cyc;
    repeat (5) @(negedge clk);
  endtask

  // driver: changes the line and pushes the expected capture (R7 latency = 3 edges)
  task automatic edge_to(input logic lvl, input bit exp, input string tag);
    item_t it;
    int c;
    @(negedge clk);
    rx_pin = lvl;
    c = cyc + 3;
    if (exp) begin
      it.lvl = lvl; it.tag = tag;
      if (clk_direct) it.cnt = 16'(c - 1 - base);
      else            it.cnt = 16'((c - 1 - en_cyc) / (2 * (int'(div) + 1)));
      q.push_back(it);
      if (reload) base = c;
    end
    repeat (8) @(negedge clk);
  endtask

  // monitor: pops on each raised capture flag, then clears it (R8)
  initial begin
    bit pend = 1'b0;
    item_t it;
    forever begin
      @(negedge clk);
      if (pend) begin
        cflag_clr = 1'b0; pend = 1'b0;
        check(cap_flag == 1'b0, "R8 flag clear", int'(cap_flag), 0);
      end else if (cap_flag) begin
        if (q.size() == 0) begin
          check(1'b0, "R1/R2 unexpected capture", 1, 0);
        end else begin
          it = q.pop_front();
          check(cap_count == it.cnt, {it.tag, " count"}, int'(cap_count), int'(it.cnt));
          check(rx_level == it.lvl, "R3 level", int'(rx_level), int'(it.lvl));
        end
        cflag_clr = 1'b1; pend = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 150000);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({cap_count, rx_level, cap_flag, ovf_flag} == '0, "R11 in reset", int'(cap_count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({cap_count, rx_level, cap_flag, ovf_flag} == '0, "R11 after reset", int'(cap_flag), 0);

    // direct clock, reload on
    set_run(1'b1, 1'b0);
    edge_to(1'b0, 1'b1, "R2 fall sel00 R5 R7");
    edge_to(1'b1, 1'b0, "R2 rise ignored");
    edge_to(1'b0, 1'b1, "R4 reload R3");
    @(negedge clk) edge_sel = 2'b01;
    edge_to(1'b1, 1'b1, "R2 rise sel01");
    edge_to(1'b0, 1'b0, "R2 fall ignored");
    @(negedge clk) edge_sel = 2'b10;
    edge_to(1'b1, 1'b1, "R2 both rise");
    edge_to(1'b0, 1'b1, "R2 both fall");
    @(negedge clk) edge_sel = 2'b11;
    edge_to(1'b1, 1'b0, "R2 reserved");
    edge_to(1'b0, 1'b0, "R2 reserved");
    @(negedge clk) begin edge_sel = 2'b10; reload = 1'b0; end
    edge_to(1'b1, 1'b1, "R4 no reload a");
    edge_to(1'b0, 1'b1, "R4 no reload b");

    // inactive: disabled, then transmit mode
    @(negedge clk) reload = 1'b1;
    set_run(1'b0, 1'b0);
    edge_to(1'b1, 1'b0, "R1 disabled");
    set_run(1'b1, 1'b0);
    edge_to(1'b0, 1'b1, "R10 restart after disable");
    set_run(1'b1, 1'b1);
    edge_to(1'b1, 1'b0, "R1 transmit mode");
    set_run(1'b1, 1'b0);
    edge_to(1'b0, 1'b1, "R10 restart after tx");

    // carrier tick mode, no reload
    @(negedge clk) begin clk_direct = 1'b0; reload = 1'b0; div = 16'd0; end
    set_run(1'b0, 1'b0);
    set_run(1'b1, 1'b0);
    edge_to(1'b1, 1'b1, "R6 div0 a");
    edge_to(1'b0, 1'b1, "R6 div0 b");
    set_run(1'b0, 1'b0);
    @(negedge clk) div = 16'd3;
    set_run(1'b1, 1'b0);
    repeat (11) @(negedge clk);
    edge_to(1'b1, 1'b1, "R6 div3 a");
    edge_to(1'b0, 1'b1, "R6 div3 b");

    // overflow after 2^16 direct steps
    @(negedge clk) begin clk_direct = 1'b1; reload = 1'b1; end
    set_run(1'b0, 1'b0);
    @(negedge clk) begin enable = 1'b1; en_cyc = cyc; end
    while (cyc != en_cyc + 65535) @(negedge clk);
    check(ovf_flag == 1'b0, "R9 before wrap", int'(ovf_flag), 0);
    @(negedge clk);
    check(ovf_flag == 1'b1, "R9 at wrap", int'(ovf_flag), 1);
    @(negedge clk);
    check(ovf_flag == 1'b1, "R9 sticky", int'(ovf_flag), 1);
    oflag_clr = 1'b1;
    @(negedge clk);
    oflag_clr = 1'b0;
    check(ovf_flag == 1'b0, "R9 cleared", int'(ovf_flag), 0);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2 missing capture", q.size(), 0);
    report();
  end
endmodule